// File: doc/BRIEF.md
# Dual-Pipe Integer ALU Pair

This block holds the two integer arithmetic units of a dual-issue core: one sits in the function pipe and one in the memory pipe. Each unit takes a valid bit, a 5-bit internal opcode and two 64-bit operands every cycle. One clock edge later it returns a registered 64-bit result, a signed-overflow flag and an illegal-dispatch flag. Each unit is built from an adder/subtractor, a logic unit and a shifter. Every operation finishes in one cycle.

The two pipes do not accept the same set of operations. The memory-pipe unit adds data addresses. Its shifter also moves store data into its byte lanes by the low address bits. The function-pipe unit alone accepts multiply/divide operations and moves from the HI/LO result registers, whose values enter as shared inputs. An operation issued to the wrong pipe, or an unused opcode, is flagged illegal and produces a zero result. A shift whose amount is zero, a register move and NOP are all served by the logic unit. The shifter's operands are held at zero unless the shifter is selected.

Top module: `dpalu_pair`

## Requirements
- R1: Each pipe registers its outputs one clock after the inputs. The output valid equals the input valid of the previous cycle. A cycle with input valid low gives valid, result, overflow and illegal all 0 on the next cycle. During reset all outputs are 0.
- R2: Opcodes 1 (ADD), 2 (ADDU), 3 (SUB) and 4 (SUBU) return the 64-bit sum a+b or difference a-b, modulo 2^64.
- R3: The overflow flag is set only by the signed opcodes 1, 3, 5 and 6, when the exact signed result does not fit the operand width. Opcodes 2 and 4, and every other opcode, leave it at 0.
- R4: Opcodes 5 (ADD32) and 6 (SUB32) operate on bits 31:0 and sign-extend bit 31 of the result to 64 bits. So do the 32-bit shift opcodes 15 to 17.
- R5: Opcode 7 gives a AND b, 8 gives OR, 9 gives XOR, 10 gives NOR, 11 (move) gives a, and 0 (NOP) gives 0.
- R6: Opcodes 12, 13 and 14 shift a left, right logical and right arithmetic by b[5:0]. Opcodes 15, 16 and 17 do the same on a[31:0] by b[4:0]. A shift by zero returns a, or a[31:0] sign-extended for the 32-bit forms.
- R7: On the memory pipe, opcode 18 (address add) returns a+b with no overflow. Opcode 19 (store align) returns b shifted left by 8 times a[2:0].
- R8: On the function pipe, opcode 20 (multiply/divide hand-off) returns 0, opcode 21 returns the HI input and opcode 22 returns the LO input, with illegal 0. On the memory pipe, opcodes 20 to 22 set illegal.
- R9: Opcodes 18 and 19 on the function pipe are illegal, and opcodes 23 to 31 are illegal on both pipes. An illegal operation gives a result of 0 and an overflow flag of 0.
- R10: The two pipes are independent. Operations issued in the same cycle never affect each other's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| f_vld_i | input | 1 | Function-pipe operation valid |
| f_op_i | input | 5 | Function-pipe opcode |
| f_a_i | input | 64 | Function-pipe operand a |
| f_b_i | input | 64 | Function-pipe operand b |
| m_vld_i | input | 1 | Memory-pipe operation valid |
| m_op_i | input | 5 | Memory-pipe opcode |
| m_a_i | input | 64 | Memory-pipe operand a (base address for opcodes 18 and 19) |
| m_b_i | input | 64 | Memory-pipe operand b (store data for opcode 19) |
| hi_i | input | 64 | Current HI register value |
| lo_i | input | 64 | Current LO register value |
| f_vld_o | output | 1 | Function-pipe result valid |
| f_res_o | output | 64 | Function-pipe result |
| f_ovf_o | output | 1 | Function-pipe signed overflow |
| f_ill_o | output | 1 | Function-pipe illegal dispatch |
| m_vld_o | output | 1 | Memory-pipe result valid |
| m_res_o | output | 64 | Memory-pipe result |
| m_ovf_o | output | 1 | Memory-pipe signed overflow |
| m_ill_o | output | 1 | Memory-pipe illegal dispatch |

## Verification
Both pipes can finish in the same cycle. One may complete a legal operation, such as an address add or a store align, while the other flags an illegal dispatch or reads HI/LO. The bench provokes this by issuing random opcodes to both pipes on every cycle. It also sends directed pairs: the same HI/LO move to both pipes, and store align alongside address add on the function pipe. Each pipe's outputs are compared one cycle later against a per-pipe reference model, so a flag or result leaking from one pipe into the other shows up as a mismatch.

// File: rtl/dpalu_pkg.sv
package dpalu_pkg;

    localparam int XLEN   = 64;
    localparam int HLEN   = XLEN / 2;
    localparam int OPW    = 5;
    localparam int SHW    = $clog2(XLEN);
    localparam int BOFFW  = $clog2(XLEN / 8);

    typedef enum logic [OPW-1:0] {
        OP_NOP    = 5'd0,
        OP_ADD    = 5'd1,
        OP_ADDU   = 5'd2,
        OP_SUB    = 5'd3,
        OP_SUBU   = 5'd4,
        OP_ADD32  = 5'd5,
        OP_SUB32  = 5'd6,
        OP_AND    = 5'd7,
        OP_OR     = 5'd8,
        OP_XOR    = 5'd9,
        OP_NOR    = 5'd10,
        OP_MOV    = 5'd11,
        OP_SLL    = 5'd12,
        OP_SRL    = 5'd13,
        OP_SRA    = 5'd14,
        OP_SLL32  = 5'd15,
        OP_SRL32  = 5'd16,
        OP_SRA32  = 5'd17,
        OP_ADDR   = 5'd18,
        OP_STALGN = 5'd19,
        OP_MDU    = 5'd20,
        OP_MFHI   = 5'd21,
        OP_MFLO   = 5'd22
    } op_e;

    typedef enum logic [1:0] {
        SH_LL = 2'd0,
        SH_RL = 2'd1,
        SH_RA = 2'd2
    } sh_mode_e;

    typedef enum logic [1:0] {
        U_NONE  = 2'd0,
        U_ADD   = 2'd1,
        U_LOGIC = 2'd2,
        U_SHIFT = 2'd3
    } unit_e;

    typedef struct packed {
        logic            vld;
        logic [XLEN-1:0] res;
        logic            ovf;
        logic            ill;
    } pipe_out_t;

endpackage

// File: rtl/dpalu_adder.sv
module dpalu_adder
    import dpalu_pkg::*;
(
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic            sub_i,
    input  logic            narrow_i,
    output logic [XLEN-1:0] sum_o,
    output logic            ovf_o
);

    logic [XLEN-1:0] b_eff;
    logic [XLEN-1:0] raw;
    logic            ovf_wide;
    logic            ovf_narrow;

    always_comb begin
        b_eff      = sub_i ? ~b_i : b_i;
        raw        = a_i + b_eff + {{(XLEN-1){1'b0}}, sub_i};
        ovf_wide   = (a_i[XLEN-1] == b_eff[XLEN-1]) && (raw[XLEN-1] != a_i[XLEN-1]);
        ovf_narrow = (a_i[HLEN-1] == b_eff[HLEN-1]) && (raw[HLEN-1] != a_i[HLEN-1]);
        if (narrow_i) begin
            sum_o = {{HLEN{raw[HLEN-1]}}, raw[HLEN-1:0]};
            ovf_o = ovf_narrow;
        end else begin
            sum_o = raw;
            ovf_o = ovf_wide;
        end
    end

endmodule

// File: rtl/dpalu_logic.sv
module dpalu_logic
    import dpalu_pkg::*;
(
    input  logic [OPW-1:0]  op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic [XLEN-1:0] hi_i,
    input  logic [XLEN-1:0] lo_i,
    output logic [XLEN-1:0] out_o
);

    logic [XLEN-1:0] a_sext;

    always_comb begin
        a_sext = {{HLEN{a_i[HLEN-1]}}, a_i[HLEN-1:0]};
        case (op_e'(op_i))
            OP_AND:                     out_o = a_i & b_i;
            OP_OR:                      out_o = a_i | b_i;
            OP_XOR:                     out_o = a_i ^ b_i;
            OP_NOR:                     out_o = ~(a_i | b_i);
            OP_MOV:                     out_o = a_i;
            OP_SLL, OP_SRL, OP_SRA:     out_o = a_i;
            OP_SLL32, OP_SRL32, OP_SRA32: out_o = a_sext;
            OP_MFHI:                    out_o = hi_i;
            OP_MFLO:                    out_o = lo_i;
            default:                    out_o = '0;
        endcase
    end

endmodule

// File: rtl/dpalu_shifter.sv
module dpalu_shifter
    import dpalu_pkg::*;
(
    input  logic            en_i,
    input  sh_mode_e        mode_i,
    input  logic            narrow_i,
    input  logic [XLEN-1:0] src_i,
    input  logic [SHW-1:0]  amt_i,
    output logic [XLEN-1:0] out_o
);

    logic [XLEN-1:0] src_g;
    logic [SHW-1:0]  amt_g;
    logic [HLEN-1:0] half;
    logic [HLEN-1:0] half_r;
    logic [XLEN-1:0] wide_r;

    always_comb begin
        // operand isolation: an idle shifter sees zeros
        src_g = en_i ? src_i : '0;
        amt_g = en_i ? amt_i : '0;
        half  = src_g[HLEN-1:0];
        case (mode_i)
            SH_RL:   half_r = half >> amt_g[SHW-2:0];
            SH_RA:   half_r = $signed(half) >>> amt_g[SHW-2:0];
            default: half_r = half << amt_g[SHW-2:0];
        endcase
        case (mode_i)
            SH_RL:   wide_r = src_g >> amt_g;
            SH_RA:   wide_r = $signed(src_g) >>> amt_g;
            default: wide_r = src_g << amt_g;
        endcase
        out_o = narrow_i ? {{HLEN{half_r[HLEN-1]}}, half_r} : wide_r;
    end

endmodule

// File: rtl/dpalu_pipe.sv
module dpalu_pipe
    import dpalu_pkg::*;
#(
    parameter bit MEM_PIPE = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vld_i,
    input  logic [OPW-1:0]  op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic [XLEN-1:0] hi_i,
    input  logic [XLEN-1:0] lo_i,
    output logic            vld_o,
    output logic [XLEN-1:0] res_o,
    output logic            ovf_o,
    output logic            ill_o
);

    pipe_out_t       st_d, st_q;
    unit_e           sel;
    logic            ill;
    logic            ovf_en;
    logic            add_sub, add_nar;
    logic            sh_en, sh_nar;
    sh_mode_e        sh_mode;
    logic [XLEN-1:0] sh_src;
    logic [SHW-1:0]  sh_amt;
    logic [XLEN-1:0] add_sum, lg_out, sh_out;
    logic            add_ovf;

    dpalu_adder u_add (
        .a_i(a_i), .b_i(b_i), .sub_i(add_sub), .narrow_i(add_nar),
        .sum_o(add_sum), .ovf_o(add_ovf)
    );

    dpalu_logic u_logic (
        .op_i(op_i), .a_i(a_i), .b_i(b_i), .hi_i(hi_i), .lo_i(lo_i),
        .out_o(lg_out)
    );

    dpalu_shifter u_shift (
        .en_i(sh_en), .mode_i(sh_mode), .narrow_i(sh_nar),
        .src_i(sh_src), .amt_i(sh_amt), .out_o(sh_out)
    );

    always_comb begin
        st_d    = '0;
        sel     = U_NONE;
        ill     = 1'b0;
        ovf_en  = 1'b0;
        add_sub = 1'b0;
        add_nar = 1'b0;
        sh_mode = SH_LL;
        sh_nar  = 1'b0;
        sh_src  = a_i;
        sh_amt  = b_i[SHW-1:0];

        case (op_e'(op_i))
            OP_ADD:   begin sel = U_ADD; ovf_en = 1'b1; end
            OP_ADDU:  sel = U_ADD;
            OP_SUB:   begin sel = U_ADD; add_sub = 1'b1; ovf_en = 1'b1; end
            OP_SUBU:  begin sel = U_ADD; add_sub = 1'b1; end
            OP_ADD32: begin sel = U_ADD; add_nar = 1'b1; ovf_en = 1'b1; end
            OP_SUB32: begin
                sel = U_ADD; add_sub = 1'b1; add_nar = 1'b1; ovf_en = 1'b1;
            end
            OP_ADDR: begin
                if (MEM_PIPE) sel = U_ADD;
                else          ill = 1'b1;
            end
            OP_NOP, OP_AND, OP_OR, OP_XOR, OP_NOR, OP_MOV: sel = U_LOGIC;
            OP_SLL, OP_SRL, OP_SRA: begin
                sh_mode = (op_e'(op_i) == OP_SLL) ? SH_LL :
                          (op_e'(op_i) == OP_SRL) ? SH_RL : SH_RA;
                sel = (b_i[SHW-1:0] != '0) ? U_SHIFT : U_LOGIC;
            end
            OP_SLL32, OP_SRL32, OP_SRA32: begin
                sh_mode = (op_e'(op_i) == OP_SLL32) ? SH_LL :
                          (op_e'(op_i) == OP_SRL32) ? SH_RL : SH_RA;
                sh_nar  = 1'b1;
                sh_amt  = {1'b0, b_i[SHW-2:0]};
                sel = (b_i[SHW-2:0] != '0) ? U_SHIFT : U_LOGIC;
            end
            OP_STALGN: begin
                if (MEM_PIPE) begin
                    sel    = U_SHIFT;
                    sh_src = b_i;
                    sh_amt = {a_i[BOFFW-1:0], 3'b000};
                end else begin
                    ill = 1'b1;
                end
            end
            OP_MDU: begin
                if (MEM_PIPE) ill = 1'b1;
            end
            OP_MFHI, OP_MFLO: begin
                if (MEM_PIPE) ill = 1'b1;
                else          sel = U_LOGIC;
            end
            default: ill = 1'b1;
        endcase

        sh_en = (sel == U_SHIFT);

        if (vld_i) begin
            st_d.vld = 1'b1;
            st_d.ill = ill;
            case (sel)
                U_ADD: begin
                    st_d.res = add_sum;
                    st_d.ovf = ovf_en & add_ovf;
                end
                U_LOGIC: st_d.res = lg_out;
                U_SHIFT: st_d.res = sh_out;
                default: st_d.res = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o = st_q.vld;
    assign res_o = st_q.res;
    assign ovf_o = st_q.ovf;
    assign ill_o = st_q.ill;

    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> vld_o);

    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> (!vld_o && res_o == '0 && !ovf_o && !ill_o));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && (op_i == OP_ADDU || op_i == OP_SUBU || op_i == OP_ADDR)) |=> !ovf_o);

    p_zero_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && op_i == OP_SLL && b_i[SHW-1:0] == '0) |=> res_o == $past(a_i));

    p_illegal_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ill_o |-> (res_o == '0 && !ovf_o));

    generate
        if (MEM_PIPE) begin : g_mem_chk
            p_mdu_on_mem_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (vld_i && (op_i == OP_MDU || op_i == OP_MFHI || op_i == OP_MFLO)) |=> ill_o);
        end else begin : g_fn_chk
            p_mem_op_on_fn_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (vld_i && (op_i == OP_ADDR || op_i == OP_STALGN)) |=> ill_o);
            p_hi_move_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (vld_i && op_i == OP_MFHI) |=> (res_o == $past(hi_i) && !ill_o));
        end
    endgenerate

endmodule

// File: rtl/dpalu_pair.sv
module dpalu_pair
    import dpalu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            f_vld_i,
    input  logic [OPW-1:0]  f_op_i,
    input  logic [XLEN-1:0] f_a_i,
    input  logic [XLEN-1:0] f_b_i,
    input  logic            m_vld_i,
    input  logic [OPW-1:0]  m_op_i,
    input  logic [XLEN-1:0] m_a_i,
    input  logic [XLEN-1:0] m_b_i,
    input  logic [XLEN-1:0] hi_i,
    input  logic [XLEN-1:0] lo_i,
    output logic            f_vld_o,
    output logic [XLEN-1:0] f_res_o,
    output logic            f_ovf_o,
    output logic            f_ill_o,
    output logic            m_vld_o,
    output logic [XLEN-1:0] m_res_o,
    output logic            m_ovf_o,
    output logic            m_ill_o
);

    localparam int NPIPE = 2;

    logic [NPIPE-1:0]           vld_in, vld_out, ovf_out, ill_out;
    logic [NPIPE-1:0][OPW-1:0]  op_in;
    logic [NPIPE-1:0][XLEN-1:0] a_in, b_in, res_out;

    assign vld_in = {m_vld_i, f_vld_i};
    assign op_in  = {m_op_i,  f_op_i};
    assign a_in   = {m_a_i,   f_a_i};
    assign b_in   = {m_b_i,   f_b_i};

    // index 0: function pipe, index 1: memory pipe
    generate
        for (genvar p = 0; p < NPIPE; p++) begin : g_pipe
            dpalu_pipe #(.MEM_PIPE(p == 1)) u_pipe (
                .clk(clk), .rst_n(rst_n),
                .vld_i(vld_in[p]), .op_i(op_in[p]),
                .a_i(a_in[p]), .b_i(b_in[p]),
                .hi_i(hi_i), .lo_i(lo_i),
                .vld_o(vld_out[p]), .res_o(res_out[p]),
                .ovf_o(ovf_out[p]), .ill_o(ill_out[p])
            );
        end
    endgenerate

    assign f_vld_o = vld_out[0];
    assign f_res_o = res_out[0];
    assign f_ovf_o = ovf_out[0];
    assign f_ill_o = ill_out[0];
    assign m_vld_o = vld_out[1];
    assign m_res_o = res_out[1];
    assign m_ovf_o = ovf_out[1];
    assign m_ill_o = ill_out[1];

endmodule

// File: tb/dpalu_pair_tb.sv
module dpalu_pair_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        f_vld_i = 1'b0, m_vld_i = 1'b0;
    logic [4:0]  f_op_i = '0, m_op_i = '0;
    logic [63:0] f_a_i = '0, f_b_i = '0, m_a_i = '0, m_b_i = '0;
    logic [63:0] hi_i = '0, lo_i = '0;
    logic        f_vld_o, f_ovf_o, f_ill_o, m_vld_o, m_ovf_o, m_ill_o;
    logic [63:0] f_res_o, m_res_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpalu_pair u_dut (
        .clk(clk), .rst_n(rst_n),
        .f_vld_i(f_vld_i), .f_op_i(f_op_i), .f_a_i(f_a_i), .f_b_i(f_b_i),
        .m_vld_i(m_vld_i), .m_op_i(m_op_i), .m_a_i(m_a_i), .m_b_i(m_b_i),
        .hi_i(hi_i), .lo_i(lo_i),
        .f_vld_o(f_vld_o), .f_res_o(f_res_o), .f_ovf_o(f_ovf_o), .f_ill_o(f_ill_o),
        .m_vld_o(m_vld_o), .m_res_o(m_res_o), .m_ovf_o(m_ovf_o), .m_ill_o(m_ill_o)
    );

    // reference: returns {vld, ill, ovf, res}
    function automatic logic [66:0] model(bit mem, logic v, logic [4:0] op,
                                          logic [63:0] a, logic [63:0] b,
                                          logic [63:0] hi, logic [63:0] lo);
        logic [64:0] s;
        logic [32:0] s3;
        logic [31:0] t;
        logic [63:0] r;
        logic        o, il;
        r = '0; o = 1'b0; il = 1'b0;
        case (op)
            5'd1:  begin s = {a[63], a} + {b[63], b}; r = s[63:0]; o = s[64] ^ s[63]; end
            5'd2:  r = a + b;
            5'd3:  begin s = {a[63], a} - {b[63], b}; r = s[63:0]; o = s[64] ^ s[63]; end
            5'd4:  r = a - b;
            5'd5:  begin s3 = {a[31], a[31:0]} + {b[31], b[31:0]};
                         r = {{32{s3[31]}}, s3[31:0]}; o = s3[32] ^ s3[31]; end
            5'd6:  begin s3 = {a[31], a[31:0]} - {b[31], b[31:0]};
                         r = {{32{s3[31]}}, s3[31:0]}; o = s3[32] ^ s3[31]; end
            5'd7:  r = a & b;
            5'd8:  r = a | b;
            5'd9:  r = a ^ b;
            5'd10: r = ~(a | b);
            5'd11: r = a;
            5'd0:  r = '0;
            5'd12: r = a << b[5:0];
            5'd13: r = a >> b[5:0];
            5'd14: r = 64'($signed(a) >>> b[5:0]);
            5'd15: begin t = a[31:0] << b[4:0]; r = {{32{t[31]}}, t}; end
            5'd16: begin t = a[31:0] >> b[4:0]; r = {{32{t[31]}}, t}; end
            5'd17: begin t = 32'($signed(a[31:0]) >>> b[4:0]); r = {{32{t[31]}}, t}; end
            5'd18: if (mem) r = a + b; else il = 1'b1;
            5'd19: if (mem) r = b << (8 * a[2:0]); else il = 1'b1;
            5'd20: il = mem;
            5'd21: if (mem) il = 1'b1; else r = hi;
            5'd22: if (mem) il = 1'b1; else r = lo;
            default: il = 1'b1;
        endcase
        if (il) begin r = '0; o = 1'b0; end
        if (!v) return '0;
        return {1'b1, il, o, r};
    endfunction

    function automatic string tag_of(bit mem, logic v, logic [4:0] op);
        if (!v) return "R1";
        if (op >= 5'd1 && op <= 5'd4)   return "R2";
        if (op == 5'd5 || op == 5'd6)   return "R4";
        if (op <= 5'd11)                return "R5";
        if (op <= 5'd17)                return "R6";
        if (op <= 5'd19)                return mem ? "R7" : "R9";
        if (op <= 5'd22)                return "R8";
        return "R9";
    endfunction

    task automatic chk(string tag, string what, logic [66:0] act, logic [66:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // entered at a negedge; drives, waits one edge, checks at the next negedge
    task automatic step(logic fv, logic [4:0] fop, logic [63:0] fa, logic [63:0] fb,
                        logic mv, logic [4:0] mop, logic [63:0] ma, logic [63:0] mb,
                        logic [63:0] hi, logic [63:0] lo, string extra);
        logic [66:0] ef, em;
        f_vld_i = fv; f_op_i = fop; f_a_i = fa; f_b_i = fb;
        m_vld_i = mv; m_op_i = mop; m_a_i = ma; m_b_i = mb;
        hi_i = hi; lo_i = lo;
        ef = model(1'b0, fv, fop, fa, fb, hi, lo);
        em = model(1'b1, mv, mop, ma, mb, hi, lo);
        @(posedge clk);
        @(negedge clk);
        chk({tag_of(1'b0, fv, fop), " ", extra}, $sformatf("fpipe op=%0d", fop),
            {f_vld_o, f_ill_o, f_ovf_o, f_res_o}, ef);
        chk({tag_of(1'b1, mv, mop), " R10 ", extra}, $sformatf("mpipe op=%0d", mop),
            {m_vld_o, m_ill_o, m_ovf_o, m_res_o}, em);
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [63:0] fb, mb;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "reset fpipe", {f_vld_o, f_ill_o, f_ovf_o, f_res_o}, '0);
        chk("R1", "reset mpipe", {m_vld_o, m_ill_o, m_ovf_o, m_res_o}, '0);
        rst_n = 1'b1;

        // R3: signed overflow versus unsigned
        step(1, 5'd1, 64'h7fff_ffff_ffff_ffff, 64'd1,
             1, 5'd2, 64'h7fff_ffff_ffff_ffff, 64'd1, '0, '0, "R3 add ovf");
        step(1, 5'd3, 64'h8000_0000_0000_0000, 64'd1,
             1, 5'd4, 64'h0, 64'd1, '0, '0, "R3 sub ovf");
        // R4: narrow add overflows and sign-extends
        step(1, 5'd5, 64'h0000_0000_7fff_ffff, 64'd1,
             1, 5'd6, 64'hffff_ffff_8000_0000, 64'd1, '0, '0, "R3 R4 narrow");
        // R6: zero-amount shifts
        step(1, 5'd12, 64'hdead_beef_1234_5678, 64'hffc0,
             1, 5'd17, 64'h1234_5678_8000_0001, 64'h20, '0, '0, "R6 zero shift");
        step(1, 5'd14, 64'h8000_0000_0000_0000, 64'd63,
             1, 5'd16, 64'h0, 64'd31, '0, '0, "R6 max shift");
        // R7 with R9: store align on mem beside address add on func
        step(1, 5'd18, 64'h1000, 64'h8,
             1, 5'd19, 64'h5, 64'hab, '0, '0, "R7 R9 align");
        step(1, 5'd19, 64'h7, 64'h1,
             1, 5'd18, 64'hffff_ffff_ffff_fff0, 64'h20, '0, '0, "R7 R9 addr");
        // R8: HI/LO moves on both pipes in the same cycle
        step(1, 5'd21, '0, '0, 1, 5'd21, '0, '0,
             64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, "R8 mfhi");
        step(1, 5'd22, '0, '0, 1, 5'd20, '0, '0,
             64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, "R8 mflo");
        // R9: unused opcode, R5: NOP and move
        step(1, 5'd31, 64'h1, 64'h1, 1, 5'd23, 64'h1, 64'h1, '0, '0, "R9 unused");
        step(1, 5'd0, 64'h1, 64'h1, 1, 5'd11, 64'hcafe, 64'h1, '0, '0, "R5 nop mov");
        // R1: valid low
        step(0, 5'd1, 64'h1, 64'h1, 0, 5'd31, 64'h1, 64'h1, '0, '0, "R1 idle");

        // random mixed traffic, both pipes every cycle
        for (int i = 0; i < 3000; i++) begin
            fb = rnd64();
            mb = rnd64();
            if ($urandom_range(0, 3) == 0) fb[5:0] = '0;
            if ($urandom_range(0, 3) == 0) mb[5:0] = '0;
            step($urandom_range(0, 7) != 0, 5'($urandom_range(0, 31)), rnd64(), fb,
                 $urandom_range(0, 7) != 0, 5'($urandom_range(0, 31)), rnd64(), mb,
                 rnd64(), rnd64(), "rand");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule